// File: doc/BRIEF.md
# Dual Wiper Register Controller with Serial Slave Port

This block is the digital core of a dual 64-position digital potentiometer. It sits behind a four-wire serial slave port and holds one live tap code for each of the two potentiometers. It also holds a small bank of stored settings per potentiometer, which stand in for nonvolatile cells. The SCK, CS and MOSI pins are brought into the system clock domain through a synchronizer, and all decoding runs on the system clock. For this reason SCK must be several times slower than the system clock.

Every transfer opens with an identity byte that carries a fixed 6-bit prefix and two bits that must equal the strap inputs. An instruction byte follows. It picks the operation, the target potentiometer and, for stored settings, one of four slots. A data byte then moves in or out. A write to a stored slot starts an emulated programming interval. During that interval a status poll reports busy, and all register writes are refused. When reset is released, slot 0 of each potentiometer is copied into that potentiometer's live tap code. The stored slots themselves are not cleared by reset.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: The port works in SPI mode 0 (SCK idles low) and mode 3 (SCK idles high). MOSI is sampled on each rising SCK edge, MSB first. MISO moves to its next bit after a rising edge and is therefore valid at the following rising edge.
- R2: The first byte must be 0,1,0,1,0,0 followed by the two strap bits (bit 1 = strap[1], bit 0 = strap[0]). If it does not match, the rest of the transfer is ignored: miso_oe stays low and no register changes.
- R3: Instruction 1001_000P reads the live tap code of pot P. The value is shifted out on the 8 SCK cycles after the instruction byte.
- R4: Instruction 1010_000P writes the data byte to the live tap code of pot P. The tap output changes only after CS rises.
- R5: Instruction 1011_SS0P reads stored slot SS of pot P.
- R6: Instruction 1100_SS0P writes stored slot SS of pot P. It then holds the write-busy flag for NV_BUSY_CYCLES system clocks.
- R7: Instruction 0101_0001 returns a status byte. Bit 0 is the write-busy flag and bits 7:1 are 0.
- R8: At reset the live tap code of every pot starts as initial content INIT_TAP. Stored slot 0 of each pot is loaded into its live tap code. The stored slots keep their contents through reset.
- R9: While the write-busy flag is set, writes to the live tap codes and to the stored slots are ignored.
- R10: While wp_n is low, writes to stored slots are ignored and no busy interval starts. Writes to the live tap codes and all reads still work.
- R11: Only data bits 5:0 are stored. Read data returns bits 7:6 as 0.
- R12: A write takes effect only if CS rises after exactly 24 SCK bits. An unknown instruction is ignored and leaves miso_oe low.
- R13: miso_oe is low while CS is high and during the two header bytes. It is high during the data byte of a valid read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| wp_n | input | 1 | Active-low protect for stored slot writes |
| strap | input | 2 | Board-level address straps |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| tap0 | output | 6 | Live tap code of pot 0 |
| tap1 | output | 6 | Live tap code of pot 1 |

## Verification
The bench issues transfers with the wrong identity byte and checks two things: the bus stays undriven, and the taps hold. A design that checked only the prefix would answer another device's traffic. It also sends writes cut one bit short and writes one bit too long. A design that committed on the eighth data bit, rather than on CS rising, would change a tap on an aborted frame. Writes are sent inside the busy window and under write protect to catch designs that accept them or start a busy interval anyway. A reset after a slot 0 write shows whether the taps recall the stored value rather than a constant.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int N_POT    = 2;
  localparam int DR_DEPTH = 4;
  localparam int DR_IDX_W = 2;
  localparam logic [5:0] ID_PREFIX = 6'b010100;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_WCR,
    OP_WR_WCR,
    OP_RD_DR,
    OP_WR_DR,
    OP_STATUS
  } op_t;

  // Instruction byte to operation; slot and pot fields are picked off separately.
  function automatic op_t decode_op(input logic [7:0] ins);
    op_t r;
    casez (ins)
      8'b1001_000?: r = OP_RD_WCR;
      8'b1010_000?: r = OP_WR_WCR;
      8'b1011_??0?: r = OP_RD_DR;
      8'b1100_??0?: r = OP_WR_DR;
      8'b0101_0001: r = OP_STATUS;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction

  function automatic logic is_read(input op_t o);
    return (o == OP_RD_WCR) || (o == OP_RD_DR) || (o == OP_STATUS);
  endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dpot_frame.sv
module dpot_frame
  import dpot_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_s,
  input  logic                sck_s,
  input  logic                mosi_s,
  input  logic [1:0]          strap,
  input  logic [7:0]          rd_data,
  output op_t                 op,
  output logic                pot,
  output logic [DR_IDX_W-1:0] idx,
  output logic [TAP_W-1:0]    wdata,
  output logic                wr_wcr_stb,
  output logic                wr_dr_stb,
  output logic                miso,
  output logic                miso_oe
);

  localparam logic [4:0] BIT_ID   = 5'd7;
  localparam logic [4:0] BIT_INS  = 5'd15;
  localparam logic [4:0] BIT_DAT  = 5'd23;
  localparam logic [4:0] FULL_CNT = 5'd24;
  localparam logic [4:0] SAT_CNT  = 5'd25;

  logic       sck_q, cs_q, id_ok, ld_req;
  logic [4:0] cnt;
  logic [7:0] shreg, nxt, tx;
  logic       sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;
  assign nxt      = {shreg[6:0], mosi_s};
  assign miso     = tx[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      shreg      <= '0;
      cnt        <= '0;
      id_ok      <= 1'b0;
      ld_req     <= 1'b0;
      op         <= OP_NONE;
      pot        <= 1'b0;
      idx        <= '0;
      wdata      <= '0;
      tx         <= '0;
      miso_oe    <= 1'b0;
      wr_wcr_stb <= 1'b0;
      wr_dr_stb  <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      cs_q       <= cs_s;
      wr_wcr_stb <= cs_rise && (cnt == FULL_CNT) && (op == OP_WR_WCR);
      wr_dr_stb  <= cs_rise && (cnt == FULL_CNT) && (op == OP_WR_DR);
      ld_req     <= 1'b0;
      if (cs_s) begin
        cnt     <= '0;
        id_ok   <= 1'b0;
        op      <= OP_NONE;
        miso_oe <= 1'b0;
        tx      <= '0;
      end else begin
        if (ld_req && is_read(op)) begin
          tx      <= rd_data;
          miso_oe <= 1'b1;
        end
        if (sck_rise) begin
          shreg <= nxt;
          if (cnt != SAT_CNT) cnt <= cnt + 5'd1;
          if (cnt == BIT_ID)
            id_ok <= (nxt[7:2] == ID_PREFIX) && (nxt[1:0] == strap);
          if (cnt == BIT_INS && id_ok) begin
            op     <= decode_op(nxt);
            pot    <= nxt[0];
            idx    <= nxt[3:2];
            ld_req <= 1'b1;
          end
          if (cnt == BIT_DAT) wdata <= nxt[TAP_W-1:0];
          if (cnt > BIT_INS && miso_oe) tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int TAP_W          = 6,
  parameter int NV_BUSY_CYCLES = 4000,
  parameter int INIT_TAP       = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  op_t                 op,
  input  logic                pot,
  input  logic [DR_IDX_W-1:0] idx,
  input  logic [TAP_W-1:0]    wdata,
  input  logic                wcr_we,
  input  logic                dr_we,
  output logic [7:0]          rd_data,
  output logic                busy,
  output logic [TAP_W-1:0]    tap0,
  output logic [TAP_W-1:0]    tap1
);

  localparam int MEM_N = N_POT * DR_DEPTH;
  localparam int CNT_W = $clog2(NV_BUSY_CYCLES + 1);

  logic [TAP_W-1:0] mem [MEM_N];
  logic [TAP_W-1:0] wcr [N_POT];
  logic [CNT_W-1:0] busy_cnt;

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = TAP_W'(INIT_TAP);
  end

  always_ff @(posedge clk) begin
    if (dr_we) mem[{pot, idx}] <= wdata;
  end

  for (genvar p = 0; p < N_POT; p++) begin : g_wcr
    always_ff @(posedge clk) begin
      if (rst)
        wcr[p] <= mem[p * DR_DEPTH];
      else if (wcr_we && pot == p[0])
        wcr[p] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      busy_cnt <= '0;
    else if (dr_we)
      busy_cnt <= CNT_W'(NV_BUSY_CYCLES);
    else if (busy_cnt != '0)
      busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);
  assign tap0 = wcr[0];
  assign tap1 = wcr[1];

  always_comb begin
    rd_data = '0;
    case (op)
      OP_RD_WCR: rd_data[TAP_W-1:0] = wcr[pot];
      OP_RD_DR:  rd_data[TAP_W-1:0] = mem[{pot, idx}];
      OP_STATUS: rd_data[0]         = busy;
      default:   rd_data            = '0;
    endcase
  end

endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
  import dpot_pkg::*;
#(
  parameter int TAP_W          = 6,
  parameter int NV_BUSY_CYCLES = 4000,
  parameter int INIT_TAP       = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             wp_n,
  input  logic [1:0]       strap,
  output logic             miso,
  output logic             miso_oe,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1
);

  logic [3:0]          pins_s;
  logic                cs_s, sck_s, mosi_s, wp_s;
  op_t                 op;
  logic                pot;
  logic [DR_IDX_W-1:0] idx;
  logic [TAP_W-1:0]    wdata;
  logic                wr_wcr_stb, wr_dr_stb;
  logic [7:0]          rd_data;
  logic                busy, wcr_we, dr_we;

  dpot_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, mosi, wp_n}),
    .q   (pins_s)
  );

  assign {cs_s, sck_s, mosi_s, wp_s} = pins_s;

  dpot_frame #(.TAP_W(TAP_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (cs_s),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .strap      (strap),
    .rd_data    (rd_data),
    .op         (op),
    .pot        (pot),
    .idx        (idx),
    .wdata      (wdata),
    .wr_wcr_stb (wr_wcr_stb),
    .wr_dr_stb  (wr_dr_stb),
    .miso       (miso),
    .miso_oe    (miso_oe)
  );

  // Busy gates every write; protect gates only stored-slot writes.
  assign wcr_we = wr_wcr_stb & ~busy;
  assign dr_we  = wr_dr_stb & ~busy & wp_s;

  dpot_regs #(
    .TAP_W          (TAP_W),
    .NV_BUSY_CYCLES (NV_BUSY_CYCLES),
    .INIT_TAP       (INIT_TAP)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .pot     (pot),
    .idx     (idx),
    .wdata   (wdata),
    .wcr_we  (wcr_we),
    .dr_we   (dr_we),
    .rd_data (rd_data),
    .busy    (busy),
    .tap0    (tap0),
    .tap1    (tap1)
  );

endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
module dpot_spi_ctrl_chk #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_s,
  input logic             wp_s,
  input logic             miso_oe,
  input logic             busy,
  input logic             dr_we,
  input logic [TAP_W-1:0] tap0,
  input logic [TAP_W-1:0] tap1
);

  assert_oe_off_deselected_R13: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso_oe);

  assert_protect_blocks_slot_R10: assert property (@(posedge clk) disable iff (rst)
    dr_we |-> wp_s);

  assert_busy_follows_slot_write_R6: assert property (@(posedge clk) disable iff (rst)
    dr_we |=> busy);

  assert_busy_only_from_write_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(dr_we));

  assert_taps_frozen_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tap0) && $stable(tap1)));

endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_s    (cs_s),
  .wp_s    (wp_s),
  .miso_oe (miso_oe),
  .busy    (busy),
  .dr_we   (dr_we),
  .tap0    (tap0),
  .tap1    (tap1)
);

// File: tb/tb_dpot_spi_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_spi_ctrl;

  localparam int HALF    = 6;
  localparam int NVB     = 1500;
  localparam int WAIT_NV = 1600;
  localparam logic [7:0] ID_OK = 8'h52;  // prefix 010100, strap 10

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       miso, miso_oe;
  logic [5:0] tap0, tap1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpot_spi_ctrl #(.NV_BUSY_CYCLES(NVB), .INIT_TAP(32)) dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n),
    .strap(strap), .miso(miso), .miso_oe(miso_oe), .tap0(tap0), .tap1(tap1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One framed transfer. rd collects MISO of the data byte; oe_hdr is set if
  // miso_oe was ever high in the header; oe_dat is set if it was high on every data bit.
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input int nbits, input bit mode3,
                      output logic [7:0] rd, output bit oe_hdr, output bit oe_dat);
    logic [31:0] w;
    w = {b0, b1, b2, 8'h00};
    rd = '0; oe_hdr = 1'b0; oe_dat = 1'b1;
    sck = mode3; clks(HALF);
    cs_n = 1'b0; clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sck = 1'b0;
      mosi = w[31-i];
      clks(HALF);
      if (i < 16) oe_hdr |= miso_oe;
      else if (i < 24) begin
        oe_dat &= miso_oe;
        rd = {rd[6:0], miso};
      end
      sck = 1'b1;
      clks(HALF);
      if (!mode3) sck = 1'b0;
    end
    clks(HALF);
    cs_n = 1'b1;
    clks(12);
  endtask

  // mode3, instr, data, wait_nv, chk_rd, exp_rd, exp_tap0, exp_tap1
  localparam int NROW = 12;
  localparam logic [38:0] TBL [NROW] = '{
    {1'b0, 8'h90, 8'h00, 1'b0, 1'b1, 8'h20, 6'h20, 6'h20}, // R3 R8 initial tap
    {1'b1, 8'hA0, 8'hC5, 1'b0, 1'b0, 8'h00, 6'h05, 6'h20}, // R4 R11 mode 3 write
    {1'b1, 8'h90, 8'h00, 1'b0, 1'b1, 8'h05, 6'h05, 6'h20}, // R1 R3 R11 mode 3 read
    {1'b0, 8'hA1, 8'h3F, 1'b0, 1'b0, 8'h00, 6'h05, 6'h3F}, // R4
    {1'b0, 8'h91, 8'h00, 1'b0, 1'b1, 8'h3F, 6'h05, 6'h3F}, // R3
    {1'b0, 8'hC9, 8'h1A, 1'b1, 1'b0, 8'h00, 6'h05, 6'h3F}, // R6 slot 2 pot 1
    {1'b0, 8'hB9, 8'h00, 1'b0, 1'b1, 8'h1A, 6'h05, 6'h3F}, // R5
    {1'b1, 8'hB8, 8'h00, 1'b0, 1'b1, 8'h20, 6'h05, 6'h3F}, // R5 other pot untouched
    {1'b0, 8'hB1, 8'h00, 1'b0, 1'b1, 8'h20, 6'h05, 6'h3F}, // R5 other slot untouched
    {1'b0, 8'hC0, 8'hFF, 1'b1, 1'b0, 8'h00, 6'h05, 6'h3F}, // R6 R11 slot 0 pot 0
    {1'b1, 8'hB0, 8'h00, 1'b0, 1'b1, 8'h3F, 6'h05, 6'h3F}, // R5 R11
    {1'b0, 8'h51, 8'h00, 1'b0, 1'b1, 8'h00, 6'h05, 6'h3F}  // R7 idle status
  };

  initial begin
    logic [7:0] rd;
    bit oh, od;
    clks(5);
    rst = 1'b0;
    clks(4);

    // Reset state
    chk("R8 reset tap0", tap0, 6'h20);
    chk("R8 reset tap1", tap1, 6'h20);
    chk("R13 reset miso_oe", miso_oe, 0);

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      logic [38:0] e;
      e = TBL[r];
      xfer(ID_OK, e[37:30], e[29:22], 24, e[38], rd, oh, od);
      if (e[21]) clks(WAIT_NV);
      if (e[20]) begin
        chk($sformatf("R1 R3 R5 R7 R11 row %0d read", r), rd, e[19:12]);
        chk($sformatf("R13 row %0d oe data", r), od, 1);
      end
      chk($sformatf("R13 row %0d oe header", r), oh, 0);
      chk($sformatf("R4 R6 row %0d tap0", r), tap0, e[11:6]);
      chk($sformatf("R4 R6 row %0d tap1", r), tap1, e[5:0]);
    end

    // Busy window: status, then writes that must be refused
    xfer(ID_OK, 8'hC4, 8'h11, 24, 1'b0, rd, oh, od);
    xfer(ID_OK, 8'h51, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R7 R6 status busy", rd, 8'h01);
    xfer(ID_OK, 8'hA0, 8'h2A, 24, 1'b0, rd, oh, od);
    chk("R9 tap write while busy", tap0, 6'h05);
    xfer(ID_OK, 8'hCC, 8'h07, 24, 1'b0, rd, oh, od);
    clks(WAIT_NV);
    xfer(ID_OK, 8'h51, 8'h00, 24, 1'b1, rd, oh, od);
    chk("R6 status after interval", rd, 8'h00);
    xfer(ID_OK, 8'hB4, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R6 slot1 pot0 written", rd, 8'h11);
    xfer(ID_OK, 8'hBC, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R9 slot3 write while busy ignored", rd, 8'h20);

    // Write protect
    wp_n = 1'b0;
    xfer(ID_OK, 8'hC5, 8'h15, 24, 1'b0, rd, oh, od);
    xfer(ID_OK, 8'h51, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R10 no busy under protect", rd, 8'h00);
    xfer(ID_OK, 8'hB5, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R10 slot write blocked, read works", rd, 8'h20);
    xfer(ID_OK, 8'hA1, 8'h09, 24, 1'b0, rd, oh, od);
    chk("R10 tap write under protect", tap1, 6'h09);
    wp_n = 1'b1;

    // Identity mismatch
    xfer(8'h51, 8'h90, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R2 strap mismatch oe header", oh, 0);
    chk("R2 strap mismatch oe data", od, 0);
    xfer(8'hD2, 8'hA0, 8'h11, 24, 1'b0, rd, oh, od);
    chk("R2 prefix mismatch write", tap0, 6'h05);

    // Bit count and unknown instruction
    xfer(ID_OK, 8'hA0, 8'h22, 23, 1'b0, rd, oh, od);
    chk("R12 23-bit write", tap0, 6'h05);
    xfer(ID_OK, 8'hA0, 8'h22, 25, 1'b1, rd, oh, od);
    chk("R12 25-bit write", tap0, 6'h05);
    xfer(ID_OK, 8'hF0, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R12 unknown instruction oe", od, 0);
    chk("R13 idle oe", miso_oe, 0);

    // Reset recall of slot 0
    @(negedge clk); rst = 1'b1;
    clks(4);
    rst = 1'b0;
    clks(4);
    chk("R8 recall tap0", tap0, 6'h3F);
    chk("R8 recall tap1", tap1, 6'h20);
    xfer(ID_OK, 8'hB9, 8'h00, 24, 1'b0, rd, oh, od);
    chk("R8 slot kept through reset", rd, 8'h1A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule